// File: doc/BRIEF.md
# Interrupt Line Router

This block steers four level-sensitive PCI interrupt request lines onto a bank of sixteen legacy interrupt outputs. Each request line has its own byte-wide route register. A value from 0 to 15 picks the output line. Any larger value switches that request line off entirely. The route registers are reached through a small byte-addressed configuration port.

Several request lines may select the same output. That output then carries the OR of all of them, as a wired-OR line would. The per-pairing request levels are held in a registered level map, and the outputs are reductions of that map. Both a change on a request input and a write to a route register therefore appear on the outputs at the next clock edge. A status pair for each request line shows whether it is routed and, if so, which output it targets.

Top module: `irq_line_router`

## Requirements
- R1: There are four route registers, one per request line, at configuration byte offsets 0x60 (line 0), 0x61 (line 1), 0x62 (line 2) and 0x63 (line 3). A write with `cfg_we` high to one of these offsets stores `cfg_wdata` at that clock edge.
- R2: After reset every route register holds 0x80. All outputs `irq_out` are low, `src_routed` is all zero and `src_line` is all zero.
- R3: `cfg_rdata` shows, in the same cycle, the stored value of the route register addressed by `cfg_addr`. It shows 0x00 for every other offset.
- R4: A write to any offset outside 0x60..0x63 is ignored: no route register and no output changes.
- R5: A route value v in 0..15 connects request line s to output v. Bit v of `irq_out` is the OR of the levels of every request line whose route value is v, so lines that share an output combine.
- R6: A route value of 16 or more disables its request line. The line then drives no output, whatever its level.
- R7: `irq_out` changes exactly one clock edge after a change on `src_req`, and it never changes before that edge.
- R8: `src_routed[s]` is 1 exactly when route register s holds a value below 16. `src_line[4s+3:4s]` then holds that value; otherwise it holds 0.
- R9: A write to a route register takes effect on `irq_out` at the same edge that stores it. An active request moves from its old output to its new one at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, combinational from `cfg_addr` |
| src_req | input | 4 | Level of each PCI interrupt request line |
| irq_out | output | 16 | Registered legacy interrupt output levels |
| src_routed | output | 4 | Per request line: route value is below 16 |
| src_line | output | 16 | Per request line: 4-bit target output, 0 when not routed |

## Verification
The bench uses the default parameters: four request lines, sixteen outputs, 8-bit routes and a window at 0x60. This configuration is small enough to drive all sixteen request patterns under every one of a few hundred pseudo-random route settings. Those settings mix disabled routes (0x10 and above) with heavily shared outputs. Every one of the 256 configuration offsets is swept for both reads and ignored writes. The one-edge latency is checked on both sides of the clock edge, and a route change is checked with its request held active.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  typedef int unsigned uint_t;

  // A route value selects an output only when it lies below the output count.
  function automatic logic route_enabled(input uint_t value, input uint_t n_dst);
    return value < n_dst;
  endfunction

  // True when a route value connects to a particular output line.
  function automatic logic route_hits(input uint_t value, input uint_t line,
                                      input uint_t n_dst);
    return route_enabled(value, n_dst) && (value == line);
  endfunction

  // Position of a (line, source) pairing in the flat level map.
  function automatic uint_t map_index(input uint_t line, input uint_t src,
                                      input uint_t n_src);
    return line * n_src + src;
  endfunction
endpackage

// File: rtl/route_regs.sv
module route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 4,
  parameter int unsigned ROUTE_W   = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h60,
  parameter logic [ROUTE_W-1:0] RESET_VAL = 'h80
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [ADDR_W-1:0]                 cfg_addr,
  input  logic [ROUTE_W-1:0]                cfg_wdata,
  output logic [ROUTE_W-1:0]                cfg_rdata,
  output logic [NUM_SRC-1:0][ROUTE_W-1:0]   route_q,
  output logic [NUM_SRC-1:0][ROUTE_W-1:0]   route_nxt
);
  localparam int unsigned LAST_ADDR = BASE_ADDR + NUM_SRC;

  logic [NUM_SRC-1:0] slot_hit;
  logic               in_window;

  assign in_window = (uint_t'(cfg_addr) >= BASE_ADDR) &&
                     (uint_t'(cfg_addr) < LAST_ADDR);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    assign slot_hit[s] = cfg_we && (cfg_addr == ADDR_W'(BASE_ADDR + s));

    always_comb begin
      route_nxt[s] = route_q[s];
      if (slot_hit[s]) route_nxt[s] = cfg_wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) route_q[s] <= RESET_VAL;
      else        route_q[s] <= route_nxt[s];
    end

    // R1
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_hit[s] |=> route_q[s] == $past(cfg_wdata));
    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_hit[s] |=> $stable(route_q[s]));
  end

  always_comb begin
    cfg_rdata = '0;
    for (int s = 0; s < int'(NUM_SRC); s++) begin
      if (cfg_addr == ADDR_W'(BASE_ADDR + uint_t'(s))) cfg_rdata = route_q[s];
    end
  end

  // R3
  rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata != '0) |-> in_window);
endmodule

// File: rtl/route_matrix.sv
module route_matrix
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned NUM_DST = 16,
  parameter int unsigned ROUTE_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0][ROUTE_W-1:0] route_nxt,
  input  logic [NUM_SRC-1:0]              src_req,
  output logic [NUM_DST-1:0]              dst_level
);
  localparam int unsigned MAP_W = NUM_DST * NUM_SRC;

  logic [MAP_W-1:0]                map_d;
  logic [MAP_W-1:0]                map_q;
  logic [NUM_SRC-1:0][NUM_DST-1:0] src_col;

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam int unsigned IDX = map_index(d, s, NUM_SRC);
      assign map_d[IDX] = src_req[s] &&
                          route_hits(uint_t'(route_nxt[s]), d, NUM_DST);
      assign src_col[s][d] = map_q[IDX];
    end
    assign dst_level[d] = |map_q[d*NUM_SRC +: NUM_SRC];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    // R5
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_col[s]));
    // R7
    level_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_col[s] != '0) |-> $past(src_req[s]));
  end
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 4,
  parameter int unsigned NUM_DST   = 16,
  parameter int unsigned ROUTE_W   = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h60,
  localparam int unsigned LINE_W   = $clog2(NUM_DST)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [ROUTE_W-1:0]         cfg_wdata,
  output logic [ROUTE_W-1:0]         cfg_rdata,
  input  logic [NUM_SRC-1:0]         src_req,
  output logic [NUM_DST-1:0]         irq_out,
  output logic [NUM_SRC-1:0]         src_routed,
  output logic [NUM_SRC*LINE_W-1:0]  src_line
);
  logic [NUM_SRC-1:0][ROUTE_W-1:0] route_q;
  logic [NUM_SRC-1:0][ROUTE_W-1:0] route_nxt;

  route_regs #(
    .NUM_SRC(NUM_SRC), .ROUTE_W(ROUTE_W), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .RESET_VAL(ROUTE_W'('h80))
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .route_q(route_q), .route_nxt(route_nxt)
  );

  route_matrix #(
    .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .ROUTE_W(ROUTE_W)
  ) u_matrix (
    .clk(clk), .rst_n(rst_n), .route_nxt(route_nxt),
    .src_req(src_req), .dst_level(irq_out)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_status
    assign src_routed[s] = route_enabled(uint_t'(route_q[s]), NUM_DST);
    assign src_line[s*LINE_W +: LINE_W] =
      src_routed[s] ? route_q[s][LINE_W-1:0] : '0;
  end

  // R7
  out_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> ($past(src_req) != '0));
  // R6
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_routed) == '0 && src_routed == '0) |-> irq_out == '0);
endmodule

// File: tb/test_irq_line_router.sv
module test_irq_line_router;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [7:0]  cfg_addr = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [7:0]  cfg_rdata;
  logic [3:0]  src_req = 0;
  logic [15:0] irq_out;
  logic [3:0]  src_routed;
  logic [15:0] src_line;

  int errors = 0;
  int checks = 0;
  logic [7:0] rt [4];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  irq_line_router i_irq_line_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_req(src_req),
    .irq_out(irq_out), .src_routed(src_routed), .src_line(src_line)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_irq(input logic [3:0] lv);
    logic [15:0] acc = 0;
    for (int s = 0; s < 4; s++)
      if (lv[s] && rt[s] < 8'd16) acc = acc | (16'd1 << rt[s]);
    return acc;
  endfunction

  function automatic logic [15:0] model_line();
    logic [15:0] v = 0;
    for (int s = 0; s < 4; s++)
      if (rt[s] < 8'd16) v[s*4 +: 4] = rt[s][3:0];
    return v;
  endfunction

  function automatic logic [3:0] model_routed();
    logic [3:0] v;
    for (int s = 0; s < 4; s++) v[s] = rt[s] < 8'd16;
    return v;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a >= 8'h60 && a <= 8'h63) rt[a - 8'h60] = d;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a);
    logic [7:0] exp;
    cfg_addr = a;
    #1;
    exp = (a >= 8'h60 && a <= 8'h63) ? rt[a - 8'h60] : 8'h00;
    check(req, {24'd0, cfg_rdata}, {24'd0, exp});
  endtask

  task automatic drive(input logic [3:0] v);
    @(negedge clk);
    src_req = v;
    @(negedge clk);
  endtask

  function automatic logic [7:0] next_route();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (lfsr[6:5] != 2'b00) return {4'h0, lfsr[3:0]};
    return lfsr[7:0] | 8'h10;
  endfunction

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    for (int s = 0; s < 4; s++) rt[s] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset state
    check("R2 irq_out", {16'd0, irq_out}, 32'd0);
    check("R2 routed", {28'd0, src_routed}, 32'd0);
    check("R2 line", {16'd0, src_line}, 32'd0);
    for (int a = 8'h60; a <= 8'h63; a++) rd_check("R2 reset value", 8'(a));
    src_req = 4'hF;
    @(negedge clk); @(negedge clk);
    check("R2/R6 unrouted at reset", {16'd0, irq_out}, 32'd0);

    // R1 R3 write then read every offset
    wr(8'h60, 8'h03); wr(8'h61, 8'h07); wr(8'h62, 8'h0B); wr(8'h63, 8'h0F);
    for (int a = 0; a < 256; a++) rd_check("R3 read sweep", 8'(a));
    @(negedge clk);
    check("R1 routes live", {16'd0, irq_out}, {16'd0, model_irq(4'hF)});

    // R4 writes outside window ignored
    for (int a = 0; a < 256; a++)
      if (a < 8'h60 || a > 8'h63) wr(8'(a), 8'h05);
    for (int a = 8'h60; a <= 8'h63; a++) rd_check("R4 window kept", 8'(a));
    check("R4 outputs kept", {16'd0, irq_out}, 32'h8888);

    // R7 latency: before the edge old value, after it new value
    @(negedge clk);
    src_req = 4'h1;
    #1 check("R7 before edge", {16'd0, irq_out}, 32'h8888);
    @(negedge clk);
    check("R7 after edge", {16'd0, irq_out}, 32'h0008);

    // R9 route moved while active
    @(negedge clk);
    cfg_we = 1; cfg_addr = 8'h60; cfg_wdata = 8'h09;
    #1 check("R9 before edge", {16'd0, irq_out}, 32'h0008);
    @(negedge clk);
    cfg_we = 0; rt[0] = 8'h09;
    check("R9 moved at write edge", {16'd0, irq_out}, 32'h0200);

    // R6 disabled values
    wr(8'h60, 8'h10); wr(8'h61, 8'hFF); wr(8'h62, 8'h80); wr(8'h63, 8'h02);
    drive(4'hF);
    check("R6 disabled routes", {16'd0, irq_out}, 32'h0004);
    check("R8 routed flags", {28'd0, src_routed}, 32'h8);
    check("R8 lines", {16'd0, src_line}, 32'h2000);

    // R5 sharing: all four on output 5
    for (int s = 0; s < 4; s++) wr(8'(8'h60 + s), 8'h05);
    for (int p = 0; p < 16; p++) begin
      drive(4'(p));
      check("R5 shared output", {16'd0, irq_out}, (p != 0) ? 32'h0020 : 32'h0);
    end

    // R5 R6 R8 pseudo-random route sweep, all request patterns
    for (int it = 0; it < 200; it++) begin
      for (int s = 0; s < 4; s++) wr(8'(8'h60 + s), next_route());
      check("R8 routed sweep", {28'd0, src_routed}, {28'd0, model_routed()});
      check("R8 line sweep", {16'd0, src_line}, {16'd0, model_line()});
      for (int p = 0; p < 16; p++) begin
        drive(4'(p));
        check("R5/R6 sweep", {16'd0, irq_out}, {16'd0, model_irq(4'(p))});
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule